// File: doc/BRIEF.md
# Touch-Panel ADC Conversion Sequencer

This block is the host-side master for one conversion on a touch-panel analog-to-digital converter with a three-wire synchronous serial link. A single-cycle start request carries an 8-bit command byte. The block then lowers chip select and runs a frame of exactly 24 serial clocks, organised as three bytes.

During the first byte it shifts the command out, most significant bit first. During the other two bytes it holds the data line low and gathers the converter's reply. When the frame ends it releases chip select and presents the 12-bit conversion value together with a one-cycle completion pulse.

The serial clock rate is set at run time. A divider input selects how many system clocks make up each half of the serial clock period. The divider value is captured when the request is accepted.

Top module: `tadc_seq`

## Requirements
- R1: After reset, and whenever idle, `cs_n` is 1 and `dclk`, `din` and `done` are 0. A reset in the middle of a frame returns these outputs to this state at once.
- R2: An accepted request produces exactly 24 rising edges on `dclk`. `cs_n` stays 0 from before the first edge until after the last one, and `dclk` is never 1 while `cs_n` is 1.
- R3: During clocks 1 to 8, `din` carries `ctrl_byte` bit 7 down to bit 0. Bit 7 is present as soon as `cs_n` falls, and each later bit changes only on a falling edge of `dclk`.
- R4: During clocks 9 to 24, `din` is 0.
- R5: `dout` is sampled on rising edges of `dclk`. The value on rising edge 10 becomes `result` bit 11, and so on down to rising edge 21, which becomes bit 0. The samples on edges 1 to 9 and 22 to 24 have no effect on `result`.
- R6: Each half of the `dclk` period lasts `div_half`+1 system clocks. The first rising edge comes one half-period after `cs_n` falls. `cs_n` rises one half-period after the 24th falling edge, so the whole frame lasts 49 half-periods.
- R7: `done` is high for exactly one cycle, in the same cycle that `cs_n` returns to 1. `result` is valid at that time and holds its value until the next `done`.
- R8: A `start` that arrives while a frame is in progress is ignored. The running frame keeps its command byte, its 24 clocks and its single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request, accepted only while idle |
| ctrl_byte | input | 8 | Command byte, captured at acceptance |
| div_half | input | DIV_W | Half-period of `dclk` minus one, in system clocks |
| cs_n | output | 1 | Active-low chip select |
| dclk | output | 1 | Serial clock, idles low |
| din | output | 1 | Serial data to the converter |
| dout | input | 1 | Serial data from the converter |
| done | output | 1 | One-cycle completion pulse |
| result | output | 12 | Conversion value |

## Verification
The converter model in the bench drives 1 on the leading don't-care edge and on all three pad edges. A design that kept the top bit, or shifted by the wrong amount, would therefore return a value that is visibly off.

Frames run with several divider values, and the bench measures the chip-select lead time and the total frame length in system clocks. An off-by-one in the divider or in the frame counter would show up as a wrong cycle count or as 23 or 25 clock edges.

A second request is injected in the middle of a frame. A design that restarted would corrupt the captured command byte or produce an extra `done`. A reset applied mid-frame must leave `dclk` low with chip select released.

// File: rtl/tadc_pkg.sv
// Shared frame constants for the touch ADC sequencer.
// Assumes a fixed 24-clock frame: one command byte followed by a 16-bit reply.
package tadc_pkg;
    localparam int CMD_BITS   = 8;
    localparam int RES_BITS   = 12;
    localparam int SKIP_BITS  = 1;                                 // leading don't-care bit of the reply
    localparam int PAD_BITS   = 3;                                 // trailing pad bits of the reply
    localparam int REPLY_BITS = SKIP_BITS + RES_BITS + PAD_BITS;   // 16
    localparam int FRAME_CLKS = CMD_BITS + REPLY_BITS;             // 24
    localparam int STEPS      = 2 * FRAME_CLKS + 1;                // half-periods up to chip-select release
    localparam int STEP_W     = $clog2(STEPS + 1);

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RISE = 2'd1,
        EV_FALL = 2'd2,
        EV_END  = 2'd3
    } tadc_ev_t;
endpackage

// File: rtl/tadc_clkdiv.sv
// Half-period tick generator for the serial clock.
// Captures the divider value on restart and ticks every lim+1 cycles while run is high.
module tadc_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] half_cnt,
    output logic             tick
);
    logic [DIV_W-1:0] lim;
    logic [DIV_W-1:0] cnt;

    // Capture the half-period length when a frame begins.
    always_ff @(posedge clk) begin
        if (!rst_n)       lim <= '0;
        else if (restart) lim <= half_cnt;
    end

    // Count system clocks within one half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) cnt <= '0;
        else if (cnt == lim)           cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

    assign tick = run && !restart && (cnt == lim);

    // With a divider above zero, two ticks are never adjacent.
    a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lim != '0) |=> !tick);
endmodule

// File: rtl/tadc_shift.sv
// Serial data path: command shifter toward the converter and reply collector from it.
// Assumes shift_out pulses on falling serial edges and sample pulses on rising ones.
module tadc_shift
    import tadc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [CMD_BITS-1:0] ctrl,
    input  logic                shift_out,
    input  logic                sample,
    input  logic                dout,
    output logic                din,
    output logic [RES_BITS-1:0] value
);
    logic [CMD_BITS-1:0]   tx;
    logic [REPLY_BITS-1:0] rx;

    // Shift the command out MSB first and fill the vacated bits with zeros.
    always_ff @(posedge clk) begin
        if (!rst_n)         tx <= '0;
        else if (load)      tx <= ctrl;
        else if (shift_out) tx <= {tx[CMD_BITS-2:0], 1'b0};
    end

    // Keep the most recent 16 reply bits.
    always_ff @(posedge clk) begin
        if (!rst_n || load) rx <= '0;
        else if (sample)    rx <= {rx[REPLY_BITS-2:0], dout};
    end

    assign din   = tx[CMD_BITS-1];
    assign value = rx[REPLY_BITS-SKIP_BITS-1 -: RES_BITS];

    // The command MSB appears on the line right after loading.
    a_r3_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> din == $past(ctrl[CMD_BITS-1]));
endmodule

// File: rtl/tadc_seq.sv
// Top of the touch ADC conversion sequencer.
// Frames one 24-clock conversion per accepted start and returns a 12-bit value.
// Assumes the converter changes dout on falling dclk edges.
module tadc_seq
    import tadc_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CMD_BITS-1:0] ctrl_byte,
    input  logic [DIV_W-1:0]    div_half,
    output logic                cs_n,
    output logic                dclk,
    output logic                din,
    input  logic                dout,
    output logic                done,
    output logic [RES_BITS-1:0] result
);
    localparam logic [STEP_W-1:0] LAST_STEP  = STEP_W'(STEPS);
    localparam logic [STEP_W-1:0] QUIET_STEP = STEP_W'(2 * CMD_BITS);

    logic                busy;
    logic [STEP_W-1:0]   step;
    logic [STEP_W-1:0]   nxt;
    logic                tick;
    logic                load;
    tadc_ev_t            ev;
    logic [RES_BITS-1:0] value;

    assign load = start && !busy;
    assign nxt  = step + 1'b1;

    // Classify the serial event that the next half-period boundary produces.
    always_comb begin
        if (!tick)                  ev = EV_NONE;
        else if (nxt == LAST_STEP)  ev = EV_END;
        else if (nxt[0])            ev = EV_RISE;
        else                        ev = EV_FALL;
    end

    tadc_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (load),
        .run      (busy),
        .half_cnt (div_half),
        .tick     (tick)
    );

    tadc_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ctrl      (ctrl_byte),
        .shift_out (ev == EV_FALL),
        .sample    (ev == EV_RISE),
        .dout      (dout),
        .din       (din),
        .value     (value)
    );

    // Frame control: busy flag, step count, serial clock level and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            step   <= '0;
            dclk   <= 1'b0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy <= 1'b1;
                step <= '0;
                dclk <= 1'b0;
            end else if (tick) begin
                step <= nxt;
                case (ev)
                    EV_RISE: dclk <= 1'b1;
                    EV_FALL: dclk <= 1'b0;
                    EV_END: begin
                        busy   <= 1'b0;
                        done   <= 1'b1;
                        result <= value;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign cs_n = !busy;

    a_r2_clock_framed: assert property (@(posedge clk) disable iff (!rst_n)
        dclk |-> !cs_n);
    a_r4_din_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && step >= QUIET_STEP) |-> !din);
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_release_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);
    a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !tick) |=> ($stable(step) && !cs_n));
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!dclk && !din));
endmodule

// File: tb/tb_tadc_seq.sv
module tb_tadc_seq;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  ctrl_byte = '0;
    logic [7:0]  div_half = '0;
    logic        dout = 1'b0;
    logic        cs_n, dclk, din, done;
    logic [11:0] result;

    int errors = 0;
    int checks = 0;

    tadc_seq #(.DIV_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ctrl_byte(ctrl_byte),
        .div_half(div_half), .cs_n(cs_n), .dclk(dclk), .din(din),
        .dout(dout), .done(done), .result(result)
    );

    always #(CLK_P/2) clk = ~clk;

    // Converter model and monitor, evaluated away from the active edge.
    logic [23:0] pat = '0;
    logic [23:0] din_cap = '0;
    int cyc = 0, nrise = 0, nfall = 0, ndone = 0;
    int t_cs = 0, t_rise = 0, t_done = 0;
    bit wide_done = 0, cs_at_done = 0;
    logic prev_cs = 1'b1, prev_dclk = 1'b0, prev_done = 1'b0;
    logic [11:0] res_at_done = '0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (prev_cs && !cs_n) begin
            t_cs = cyc; nrise = 0; nfall = 0; din_cap = '0;
            dout = pat[23];
        end
        if (!prev_dclk && dclk) begin
            nrise = nrise + 1;
            din_cap = {din_cap[22:0], din};
            if (nrise == 1) t_rise = cyc;
        end
        if (prev_dclk && !dclk) begin
            nfall = nfall + 1;
            dout = (nfall < 24) ? pat[23-nfall] : 1'b0;
        end
        if (done) begin
            ndone = ndone + 1; t_done = cyc;
            cs_at_done = cs_n; res_at_done = result;
            if (prev_done) wide_done = 1;
        end
        prev_cs = cs_n; prev_dclk = dclk; prev_done = done;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [7:0] c, input logic [7:0] d);
        @(negedge clk);
        ctrl_byte = c; div_half = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Entries: {ctrl, div_half, value}
    localparam logic [31:0] VEC [5] = '{
        {8'h93, 8'd0, 12'hA5C, 4'h0},
        {8'hD1, 8'd1, 12'h001, 4'h0},
        {8'h5A, 8'd3, 12'hFFF, 4'h0},
        {8'hE5, 8'd2, 12'h800, 4'h0},
        {8'h00, 8'd0, 12'h000, 4'h0}
    };

    task automatic run_frame(input logic [7:0] c, input logic [7:0] d, input logic [11:0] v);
        int base;
        int hp;
        base = ndone;
        hp = int'(d) + 1;
        wide_done = 0;
        // junk on edges 1..9, value on 10..21, ones on pad edges 22..24
        pat = {~c, 1'b1, v, 3'b111};
        pulse_start(c, d);
        while (ndone == base) @(posedge clk);
        repeat (3) @(posedge clk);
        chk(nrise == 24, "R2 rising edge count", nrise, 24);
        chk(din_cap[23:16] == c, "R3 command byte on din", int'(din_cap[23:16]), int'(c));
        chk(din_cap[15:0] == 16'h0, "R4 din low after command", int'(din_cap[15:0]), 0);
        chk(res_at_done == v, "R5 result value", int'(res_at_done), int'(v));
        chk(t_rise - t_cs == hp, "R6 chip-select lead", t_rise - t_cs, hp);
        chk(t_done - t_cs == 49 * hp, "R6 frame length", t_done - t_cs, 49 * hp);
        chk(cs_at_done == 1'b1 && !wide_done && ndone == base + 1, "R7 done pulse",
            ndone - base, 1);
        chk(result == v, "R7 result held", int'(result), int'(v));
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1 && dclk == 0 && din == 0 && done == 0, "R1 reset state",
            int'({cs_n, dclk, din, done}), 8);

        for (int i = 0; i < 5; i++)
            run_frame(VEC[i][31:24], VEC[i][23:16], VEC[i][15:4]);

        // R8: second request in the middle of a frame is ignored
        begin
            int base;
            base = ndone;
            wide_done = 0;
            pat = {8'h00, 1'b1, 12'h3C6, 3'b111};
            pulse_start(8'hB7, 8'd1);
            while (nrise < 5) @(posedge clk);
            pulse_start(8'h4E, 8'd0);
            while (ndone == base) @(posedge clk);
            repeat (10) @(posedge clk);
            chk(din_cap[23:16] == 8'hB7, "R8 command kept", int'(din_cap[23:16]), 'hB7);
            chk(nrise == 24, "R8 clock count kept", nrise, 24);
            chk(ndone == base + 1 && cs_n, "R8 single done", ndone - base, 1);
            chk(res_at_done == 12'h3C6, "R8 result of first frame", int'(res_at_done), 'h3C6);
        end

        // R1: reset in the middle of a frame
        pat = 24'h0;
        pulse_start(8'hFF, 8'd2);
        while (nrise < 3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(cs_n == 1 && dclk == 0 && din == 0 && done == 0, "R1 mid-frame reset",
            int'({cs_n, dclk, din, done}), 8);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(cs_n == 1 && dclk == 0, "R1 stays idle", int'({cs_n, dclk}), 2);

        run_frame(8'h69, 8'd1, 12'h7E1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule